// File: doc/BRIEF.md
# Sound Coprocessor Interval Timer Bank

This block holds three programmable interval timers for a sound coprocessor. A base tick pulse, one clock wide and produced elsewhere at the video line rate, drives all three. Each timer has an enable and an 8-bit target. Each one feeds a 4-bit event counter that the coprocessor reads and clears. Two of the timers are slow: they count one step on every second base tick and return to zero when they reach their target. The third is fast: it gains four units on each base tick, takes away the target once for each whole period that fits, and keeps the remainder for the next tick.

Every event counter increment also raises a one-cycle wake pulse. The coprocessor uses this pulse to leave an idle wait loop. A read-clear strobe for each counter lets the register interface sample the counter and zero it in a single access. The address decoding for that access sits outside this block.

Top module: `apu_interval_timers`

## Requirements
- R1: After synchronous reset, all three event counters read 0, the wake output is 0, and the next base tick counts as an even tick.
- R2: On each base tick with timer 2 enabled, its internal count gains 4. The target is then taken away once for each time the count is at or above it, up to 4 times per tick, and event counter 2 gains one per removal. The result is visible one clock after the tick.
- R3: Base ticks alternate between even and odd, starting with even after reset. Timers 0 and 1 advance by one only on odd ticks. The alternation continues even while the timers are disabled.
- R4: When the internal count of timer 0 or timer 1 reaches its target, that count returns to 0 and the matching event counter gains one.
- R5: A target value of 0 acts as a target of 256 for every timer.
- R6: A disabled timer keeps its internal count and its event counter unchanged. On re-enable it resumes from the count it held.
- R7: Each event counter is 4 bits wide and wraps from 15 to 0.
- R8: The wake output is high for exactly one clock, in the clock where an event counter has just taken an increment. It is low otherwise.
- R9: While the read-clear strobe of a counter is high, the counter shows its current value. In the next clock it reads 0 plus any increments from a base tick in the same cycle, so no events are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base tick pulse, one clock wide |
| en_i | input | 3 | Per-timer enable, bit n for timer n |
| tgt0_i | input | 8 | Target of slow timer 0 (0 means 256) |
| tgt1_i | input | 8 | Target of slow timer 1 (0 means 256) |
| tgt2_i | input | 8 | Target of fast timer 2 (0 means 256) |
| rdclr_i | input | 3 | Read-clear strobe, bit n for counter n |
| cnt0_o | output | 4 | Event counter of timer 0 |
| cnt1_o | output | 4 | Event counter of timer 1 |
| cnt2_o | output | 4 | Event counter of timer 2 |
| wake_o | output | 1 | One-clock pulse on any counter increment |

## Verification
A wrong internal count cannot be seen directly. It shows up as an event counter that steps on the wrong base tick, so the fault appears within one target period of the tick where it arose. Likewise, if the odd/even alternation slips, the slow counters fire one tick early or late. For these reasons the bench compares every counter and the wake pulse one clock after each tick. It runs sweeps of targets from 1 to 15 and 256, and it includes enable flips and strobes that coincide with ticks. Against the arithmetic model, any drift in remainder or phase is caught on the first mismatched tick.

// File: rtl/apu_tmr_pkg.sv
package apu_tmr_pkg;

    localparam int TGT_W        = 8;
    localparam int OUT_W        = 4;
    localparam int FAST_STEP    = 4;
    localparam int FAST_MAX_SUB = 4;
    localparam int INC_W        = $clog2(FAST_MAX_SUB + 1);

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } tick_phase_e;

    // Result of one fast-timer update: new remainder and number of periods.
    typedef struct packed {
        logic [TGT_W:0]   rem;
        logic [INC_W-1:0] hits;
    } fast_res_t;

    // A programmed zero selects the full range of 2**TGT_W.
    function automatic logic [TGT_W:0] eff_target(input logic [TGT_W-1:0] t);
        logic [TGT_W:0] r;
        if (t == '0) r = {1'b1, {TGT_W{1'b0}}};
        else         r = {1'b0, t};
        return r;
    endfunction

endpackage

// File: rtl/apu_tmr_slow.sv
module apu_tmr_slow
    import apu_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             en_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic             hit_o
);
    logic [TGT_W:0] cnt_q;
    logic [TGT_W:0] cnt_nxt;
    logic [TGT_W:0] teff;
    logic           adv;

    always_comb begin
        teff    = eff_target(tgt_i);
        adv     = step_i && en_i;
        cnt_nxt = cnt_q + 1'b1;
        hit_o   = adv && (cnt_nxt >= teff);
    end

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (adv)   cnt_q <= hit_o ? '0 : cnt_nxt;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(step_i && en_i) |=> $stable(cnt_q));
    p_below_target_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && en_i) |=> (cnt_q < $past(teff)));
    p_no_hit_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !step_i |-> !hit_o);
endmodule

// File: rtl/apu_tmr_fast.sv
module apu_tmr_fast
    import apu_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             en_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [INC_W-1:0] hits_o
);
    logic [TGT_W:0] cnt_q;
    logic [TGT_W:0] teff;
    fast_res_t      res;
    logic           adv;

    always_comb begin
        teff     = eff_target(tgt_i);
        adv      = step_i && en_i;
        res.rem  = cnt_q + (TGT_W+1)'(FAST_STEP);
        res.hits = '0;
        for (int k = 0; k < FAST_MAX_SUB; k++) begin
            if (res.rem >= teff) begin
                res.rem  = res.rem - teff;
                res.hits = res.hits + 1'b1;
            end
        end
        hits_o = adv ? res.hits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (adv) cnt_q <= res.rem;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(step_i && en_i) |=> $stable(cnt_q));
    p_remainder_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i && en_i) |=> (cnt_q < $past(teff)));
    p_hits_limit_r2: assert property (@(posedge clk) disable iff (rst)
        hits_o <= INC_W'(FAST_MAX_SUB));
endmodule

// File: rtl/apu_tmr_out.sv
module apu_tmr_out
    import apu_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc_i,
    input  logic             clr_i,
    output logic [OUT_W-1:0] val_o
);
    logic [OUT_W-1:0] base;

    always_comb base = clr_i ? '0 : val_o;

    always_ff @(posedge clk) begin
        if (rst) val_o <= '0;
        else     val_o <= base + OUT_W'(inc_i);
    end

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && inc_i == '0) |=> (val_o == '0));
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && inc_i == '0) |=> $stable(val_o));
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (val_o == OUT_W'($past(val_o) + OUT_W'($past(inc_i)))));
endmodule

// File: rtl/apu_interval_timers.sv
module apu_interval_timers
    import apu_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [2:0]       en_i,
    input  logic [TGT_W-1:0] tgt0_i,
    input  logic [TGT_W-1:0] tgt1_i,
    input  logic [TGT_W-1:0] tgt2_i,
    input  logic [2:0]       rdclr_i,
    output logic [OUT_W-1:0] cnt0_o,
    output logic [OUT_W-1:0] cnt1_o,
    output logic [OUT_W-1:0] cnt2_o,
    output logic             wake_o
);
    localparam int N_SLOW = 2;
    localparam int N_TMR  = N_SLOW + 1;

    tick_phase_e      phase_q;
    logic             slow_step;
    logic [TGT_W-1:0] slow_tgt [N_SLOW];
    logic [INC_W-1:0] inc      [N_TMR];
    logic [OUT_W-1:0] val      [N_TMR];
    logic             any_inc;

    always_comb begin
        slow_step   = tick_i && (phase_q == PH_ODD);
        slow_tgt[0] = tgt0_i;
        slow_tgt[1] = tgt1_i;
        any_inc     = 1'b0;
        for (int i = 0; i < N_TMR; i++) any_inc = any_inc | (inc[i] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EVEN;
            wake_o  <= 1'b0;
        end else begin
            if (tick_i) phase_q <= (phase_q == PH_ODD) ? PH_EVEN : PH_ODD;
            wake_o <= any_inc;
        end
    end

    for (genvar g = 0; g < N_SLOW; g++) begin : g_slow
        logic hit;
        apu_tmr_slow u_slow (
            .clk    (clk),
            .rst    (rst),
            .step_i (slow_step),
            .en_i   (en_i[g]),
            .tgt_i  (slow_tgt[g]),
            .hit_o  (hit)
        );
        assign inc[g] = INC_W'(hit);
    end

    apu_tmr_fast u_fast (
        .clk    (clk),
        .rst    (rst),
        .step_i (tick_i),
        .en_i   (en_i[N_SLOW]),
        .tgt_i  (tgt2_i),
        .hits_o (inc[N_SLOW])
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_out
        apu_tmr_out u_out (
            .clk   (clk),
            .rst   (rst),
            .inc_i (inc[g]),
            .clr_i (rdclr_i[g]),
            .val_o (val[g])
        );
    end

    assign cnt0_o = val[0];
    assign cnt1_o = val[1];
    assign cnt2_o = val[2];

    p_phase_flip_r3: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (phase_q != $past(phase_q)));
    p_quiet_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
        (!wake_o && $past(rdclr_i) == 3'b000) |->
        (cnt0_o == $past(cnt0_o) && cnt1_o == $past(cnt1_o) && cnt2_o == $past(cnt2_o)));
    p_no_tick_no_wake_r8: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !wake_o);
endmodule

// File: tb/apu_interval_timers_tb_top.sv
`timescale 1ns/1ps
module apu_interval_timers_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] en = 3'b000;
    logic [7:0] tgt0 = 8'd1, tgt1 = 8'd1, tgt2 = 8'd1;
    logic [2:0] rdclr = 3'b000;
    logic [3:0] cnt0, cnt1, cnt2;
    logic       wake;

    always #4 clk = ~clk;

    apu_interval_timers dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .en_i(en),
        .tgt0_i(tgt0), .tgt1_i(tgt1), .tgt2_i(tgt2), .rdclr_i(rdclr),
        .cnt0_o(cnt0), .cnt1_o(cnt1), .cnt2_o(cnt2), .wake_o(wake)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int mc [3];
    int mo [3];
    bit mph;

    function automatic int port_val(int i);
        case (i)
            0: return int'(cnt0);
            1: return int'(cnt1);
            default: return int'(cnt2);
        endcase
    endfunction

    function automatic int teff(logic [7:0] t);
        return (t == 8'd0) ? 256 : int'(t);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; rdclr = 3'b000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin mc[i] = 0; mo[i] = 0; end
        mph = 1'b0;
        chk("R1", "cnt0 after reset", int'(cnt0), 0);
        chk("R1", "cnt1 after reset", int'(cnt1), 0);
        chk("R1", "cnt2 after reset", int'(cnt2), 0);
        chk("R1", "wake after reset", int'(wake), 0);
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks after it.
    task automatic step(bit tk, logic [2:0] r);
        int inc [3];
        int prev [3];
        bit odd;
        string lbl;
        for (int i = 0; i < 3; i++)
            if (r[i]) chk("R9", "value visible during strobe", port_val(i), mo[i]);
        tick = tk; rdclr = r;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; rdclr = 3'b000;
        odd = mph;
        for (int i = 0; i < 3; i++) inc[i] = 0;
        if (tk) begin
            for (int i = 0; i < 2; i++) begin
                if (odd && en[i]) begin
                    mc[i]++;
                    if (mc[i] >= teff(i == 0 ? tgt0 : tgt1)) begin
                        mc[i] = 0;
                        inc[i] = 1;
                    end
                end
            end
            if (en[2]) begin
                mc[2] += 4;
                for (int k = 0; k < 4; k++)
                    if (mc[2] >= teff(tgt2)) begin
                        mc[2] -= teff(tgt2);
                        inc[2]++;
                    end
            end
            mph = !mph;
        end
        for (int i = 0; i < 3; i++) begin
            prev[i] = r[i] ? 0 : mo[i];
            mo[i] = (prev[i] + inc[i]) % 16;
            if (r[i])                                   lbl = "R9";
            else if (prev[i] + inc[i] > 15)             lbl = "R7";
            else if (!en[i])                            lbl = "R6";
            else if (teff(i == 0 ? tgt0 : (i == 1 ? tgt1 : tgt2)) == 256) lbl = "R5";
            else if (i == 2)                            lbl = "R2";
            else if (tk && !odd)                        lbl = "R3";
            else                                        lbl = "R4";
            chk(lbl, $sformatf("cnt%0d", i), port_val(i), mo[i]);
        end
        chk("R8", "wake pulse", int'(wake), (inc[0] + inc[1] + inc[2]) != 0 ? 1 : 0);
    endtask

    initial begin
        for (int cfg = 0; cfg < 16; cfg++) begin
            tgt2 = 8'(cfg);
            tgt0 = (cfg % 4 == 3) ? 8'd0 : 8'(cfg % 5 + 1);
            tgt1 = 8'(cfg % 3 + 1);
            en   = (cfg < 8) ? 3'b111 : 3'(cfg);
            do_reset();
            for (int n = 0; n < 80; n++) begin
                if (n == 40) en = en ^ 3'b111;
                if (n == 60) en = 3'b111;
                step(1'b1, (n % 7 == 3) ? (3'b001 << (n % 3)) : 3'b000);
                if (n % 9 == 5) step(1'b0, (n % 2 == 0) ? 3'b111 : 3'b000);
            end
        end
        // Dedicated strobe-free run to let the fast counter wrap (R7).
        tgt2 = 8'd1; en = 3'b100;
        do_reset();
        for (int n = 0; n < 6; n++) step(1'b1, 3'b000);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule